// File: doc/BRIEF.md
# Workweek Deadline Countdown Timer

This block keeps a weekly calendar clock (day of week, hour, minute, second) that moves forward one second on each cycle where a single-cycle tick input is high. From that clock it works out how much time is left before the working week ends on Friday at 17:00:00. During the working week it presents the remaining days, hours, minutes and seconds as separate two-digit BCD fields that a display driver can show directly.

Outside the working week, which is from Friday 17:00:00 through Monday 08:59:59, it raises a weekend flag so that the display can show a fixed message instead of the countdown. The user sets the current time by holding a set input and pulsing per-field step strobes. When the set input is released the clock runs on its own with no further input. The oscillator, prescaler, debouncing and display drivers lie outside the block.

Top module: `wkend_countdown`

## Requirements
- R1: A synchronous reset loads Monday 00:00:00. Day codes are 0 = Monday through 6 = Sunday.
- R2: Outside set mode, the time advances by exactly one second on each clock edge where `tick` is high. It is unchanged on every edge where `tick` is low.
- R3: Seconds and minutes wrap from 59 to 0, and each wrap carries into the next field. Hours wrap from 23 to 0 and carry into the day. The day wraps from 6 (Sunday) back to 0 (Monday).
- R4: While `set_mode` is high, `tick` has no effect on the time.
- R5: While `set_mode` is high, each of `inc_day`, `inc_hour` and `inc_min` steps its own field by one on the next edge. Each field wraps at its own limit and never carries into a neighbouring field. Outside set mode these strobes are ignored.
- R6: On the first edge after `set_mode` falls, the seconds are cleared to 0. This takes priority over `tick`, and the day, hour and minute are kept.
- R7: `weekend` is 0 exactly when the current time is at or after Monday 09:00:00 and before Friday 17:00:00. It is 1 at every other time, including Monday 00:00:00 to 08:59:59. It rises in the same cycle in which the clock shows Friday 17:00:00.
- R8: When `weekend` is 0, the remaining-time outputs give Friday 17:00:00 minus the current time, split into days (0 to 4), hours, minutes and seconds. Each output is two-digit BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0].
- R9: When `weekend` is 1, all four remaining-time outputs are 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse marking each elapsed second |
| set_mode | input | 1 | Holds the clock and enables the step strobes |
| inc_day | input | 1 | Step the day field (set mode only) |
| inc_hour | input | 1 | Step the hour field (set mode only) |
| inc_min | input | 1 | Step the minute field (set mode only) |
| cur_day | output | 3 | Current day, 0 = Monday |
| cur_hour | output | 5 | Current hour, binary 0 to 23 |
| cur_min | output | 6 | Current minute, binary 0 to 59 |
| cur_sec | output | 6 | Current second, binary 0 to 59 |
| rem_days | output | 8 | Remaining days, BCD |
| rem_hours | output | 8 | Remaining hours, BCD |
| rem_mins | output | 8 | Remaining minutes, BCD |
| rem_secs | output | 8 | Remaining seconds, BCD |
| weekend | output | 1 | High outside the working-week window |

## Verification
The bench targets the two edges of the window: Friday 16:59:59 to 17:00:00, where a design with an off-by-one compare would show a countdown of zero instead of the weekend flag, and Monday 08:59:59 to 09:00:00, where the countdown must jump to 4 days 08 hours. It also targets the Sunday-to-Monday wrap and the 59-second and 59-minute borrow chains, where a wrong borrow gives remaining values that are off by a whole minute or hour. Random set-mode bursts check that a tick in set mode or an early release does not move the seconds, that strobes outside set mode are ignored, and that a minute strobe at 59 does not carry into the hour.

// File: rtl/wkc_pkg.sv
package wkc_pkg;
    localparam int DAY_W  = 3;
    localparam int HOUR_W = 5;
    localparam int MIN_W  = 6;
    localparam int SEC_W  = 6;
    localparam int NUM_FIELDS = 4;

    typedef struct packed {
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } wtime_t;
endpackage

// File: rtl/wkc_timekeeper.sv
module wkc_timekeeper
    import wkc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   set_mode,
    input  logic   inc_day,
    input  logic   inc_hour,
    input  logic   inc_min,
    output wtime_t now
);
    localparam logic [DAY_W-1:0]  LAST_DAY  = DAY_W'(6);
    localparam logic [HOUR_W-1:0] LAST_HOUR = HOUR_W'(23);
    localparam logic [MIN_W-1:0]  LAST_MIN  = MIN_W'(59);
    localparam logic [SEC_W-1:0]  LAST_SEC  = SEC_W'(59);

    typedef struct packed {
        wtime_t t;
        logic   set_seen;
    } tk_state_t;

    tk_state_t state_d, state_q;

    always_comb begin
        state_d          = state_q;
        state_d.set_seen = set_mode;
        if (set_mode) begin
            if (inc_day)
                state_d.t.day  = (state_q.t.day  == LAST_DAY)  ? '0 : state_q.t.day  + 1'b1;
            if (inc_hour)
                state_d.t.hour = (state_q.t.hour == LAST_HOUR) ? '0 : state_q.t.hour + 1'b1;
            if (inc_min)
                state_d.t.min  = (state_q.t.min  == LAST_MIN)  ? '0 : state_q.t.min  + 1'b1;
        end else if (state_q.set_seen) begin
            state_d.t.sec = '0;
        end else if (tick) begin
            if (state_q.t.sec != LAST_SEC) begin
                state_d.t.sec = state_q.t.sec + 1'b1;
            end else begin
                state_d.t.sec = '0;
                if (state_q.t.min != LAST_MIN) begin
                    state_d.t.min = state_q.t.min + 1'b1;
                end else begin
                    state_d.t.min = '0;
                    if (state_q.t.hour != LAST_HOUR) begin
                        state_d.t.hour = state_q.t.hour + 1'b1;
                    end else begin
                        state_d.t.hour = '0;
                        state_d.t.day  = (state_q.t.day == LAST_DAY) ? '0 : state_q.t.day + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.t        <= '0;
            state_q.set_seen <= set_mode;
        end else begin
            state_q <= state_d;
        end
    end

    assign now = state_q.t;
endmodule

// File: rtl/wkc_remaining.sv
module wkc_remaining
    import wkc_pkg::*;
#(
    parameter int OPEN_DAY   = 0,
    parameter int OPEN_HOUR  = 9,
    parameter int CLOSE_DAY  = 4,
    parameter int CLOSE_HOUR = 17
) (
    input  wtime_t                now,
    output logic [NUM_FIELDS-1:0][7:0] rem_bin,
    output logic                  weekend
);
    localparam logic [7:0] ODAY  = 8'(OPEN_DAY);
    localparam logic [7:0] OHOUR = 8'(OPEN_HOUR);
    localparam logic [7:0] CDAY  = 8'(CLOSE_DAY);
    localparam logic [7:0] CHOUR = 8'(CLOSE_HOUR);
    localparam logic [7:0] SIXTY = 8'd60;
    localparam logic [7:0] HOURS_PER_DAY = 8'd24;

    logic [7:0] d, h, m, s;
    logic [7:0] xs, xm, xh;
    logic [7:0] rs, rm, rh, rd;
    logic       bs, bm, bh;

    always_comb begin
        d = 8'(now.day);
        h = 8'(now.hour);
        m = 8'(now.min);
        s = 8'(now.sec);

        // seconds: borrow from the minute whenever any seconds are left over
        xs = s;
        if (xs == 8'd0) begin rs = 8'd0;       bs = 1'b0; end
        else            begin rs = SIXTY - xs; bs = 1'b1; end

        xm = m + {7'd0, bs};
        if (xm == 8'd0) begin rm = 8'd0;       bm = 1'b0; end
        else            begin rm = SIXTY - xm; bm = 1'b1; end

        xh = h + {7'd0, bm};
        if (xh <= CHOUR) begin rh = CHOUR - xh;                 bh = 1'b0; end
        else             begin rh = CHOUR + HOURS_PER_DAY - xh; bh = 1'b1; end

        rd = CDAY - d - {7'd0, bh};

        weekend = (d > CDAY) || ((d == CDAY) && (h >= CHOUR)) ||
                  (d < ODAY) || ((d == ODAY) && (h < OHOUR));

        if (weekend) rem_bin = '0;
        else         rem_bin = {rd, rh, rm, rs};
    end
endmodule

// File: rtl/wkc_bcd_pack.sv
module wkc_bcd_pack #(
    parameter int N = 4
) (
    input  logic [N-1:0][7:0] bin,
    output logic [N-1:0][7:0] bcd
);
    for (genvar g = 0; g < N; g++) begin : g_digit
        logic [7:0] tens, units;
        assign tens   = bin[g] / 8'd10;
        assign units  = bin[g] % 8'd10;
        assign bcd[g] = {tens[3:0], units[3:0]};
    end
endmodule

// File: rtl/wkend_countdown.sv
module wkend_countdown
    import wkc_pkg::*;
#(
    parameter int OPEN_DAY   = 0,
    parameter int OPEN_HOUR  = 9,
    parameter int CLOSE_DAY  = 4,
    parameter int CLOSE_HOUR = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              set_mode,
    input  logic              inc_day,
    input  logic              inc_hour,
    input  logic              inc_min,
    output logic [DAY_W-1:0]  cur_day,
    output logic [HOUR_W-1:0] cur_hour,
    output logic [MIN_W-1:0]  cur_min,
    output logic [SEC_W-1:0]  cur_sec,
    output logic [7:0]        rem_days,
    output logic [7:0]        rem_hours,
    output logic [7:0]        rem_mins,
    output logic [7:0]        rem_secs,
    output logic              weekend
);
    wtime_t now;
    logic [NUM_FIELDS-1:0][7:0] rem_bin, rem_bcd;

    wkc_timekeeper u_time (
        .clk(clk), .rst(rst), .tick(tick), .set_mode(set_mode),
        .inc_day(inc_day), .inc_hour(inc_hour), .inc_min(inc_min),
        .now(now)
    );

    wkc_remaining #(
        .OPEN_DAY(OPEN_DAY), .OPEN_HOUR(OPEN_HOUR),
        .CLOSE_DAY(CLOSE_DAY), .CLOSE_HOUR(CLOSE_HOUR)
    ) u_rem (
        .now(now), .rem_bin(rem_bin), .weekend(weekend)
    );

    wkc_bcd_pack #(.N(NUM_FIELDS)) u_bcd (
        .bin(rem_bin), .bcd(rem_bcd)
    );

    assign cur_day   = now.day;
    assign cur_hour  = now.hour;
    assign cur_min   = now.min;
    assign cur_sec   = now.sec;
    assign rem_days  = rem_bcd[3];
    assign rem_hours = rem_bcd[2];
    assign rem_mins  = rem_bcd[1];
    assign rem_secs  = rem_bcd[0];
endmodule

// File: rtl/wkend_countdown_checker.sv
module wkend_countdown_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       set_mode,
    input logic       inc_day,
    input logic       inc_hour,
    input logic       inc_min,
    input logic [2:0] cur_day,
    input logic [4:0] cur_hour,
    input logic [5:0] cur_min,
    input logic [5:0] cur_sec,
    input logic [7:0] rem_days,
    input logic [7:0] rem_hours,
    input logic [7:0] rem_mins,
    input logic [7:0] rem_secs,
    input logic       weekend
);
    logic [19:0] clk_time;
    assign clk_time = {cur_day, cur_hour, cur_min, cur_sec};

    // R1: after a reset edge the clock shows Monday 00:00:00
    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> (clk_time == 20'd0));

    // R2: idle cycle outside set mode leaves the time untouched
    assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!set_mode && !tick && !$past(set_mode)) |=> $stable(clk_time));

    // R3: every field stays inside its range
    assert_field_range_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_sec < 6'd60) && (cur_min < 6'd60) && (cur_hour < 5'd24) && (cur_day < 3'd7));

    // R4: set mode with no strobe freezes the time
    assert_set_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        (set_mode && !inc_day && !inc_hour && !inc_min) |=> $stable(clk_time));

    // R6: leaving set mode clears the seconds
    assert_exit_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (!set_mode && $past(set_mode)) |=> (cur_sec == 6'd0));

    // R7: Friday 17:00:00 is already weekend
    assert_deadline_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (cur_day == 3'd4 && cur_hour == 5'd17 && cur_min == 6'd0 && cur_sec == 6'd0) |-> weekend);

    // R8: inside the window the day count stays within 0..4
    assert_days_range_R8: assert property (@(posedge clk) disable iff (rst)
        !weekend |-> (rem_days <= 8'h04));

    // R9: weekend blanks the countdown fields
    assert_weekend_blank_R9: assert property (@(posedge clk) disable iff (rst)
        weekend |-> ({rem_days, rem_hours, rem_mins, rem_secs} == 32'd0));
endmodule

bind wkend_countdown wkend_countdown_checker u_chk (.*);

// File: tb/wkend_countdown_bench.sv
module wkend_countdown_bench;
    logic clk = 1'b0;
    logic rst, tick, set_mode, inc_day, inc_hour, inc_min;
    logic [2:0] cur_day;
    logic [4:0] cur_hour;
    logic [5:0] cur_min, cur_sec;
    logic [7:0] rem_days, rem_hours, rem_mins, rem_secs;
    logic weekend;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // expected model state
    int e_day, e_hr, e_min, e_sec;
    bit e_setq;

    always #2 clk = ~clk;

    wkend_countdown u_wkend_countdown (
        .clk(clk), .rst(rst), .tick(tick), .set_mode(set_mode),
        .inc_day(inc_day), .inc_hour(inc_hour), .inc_min(inc_min),
        .cur_day(cur_day), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
        .rem_days(rem_days), .rem_hours(rem_hours), .rem_mins(rem_mins),
        .rem_secs(rem_secs), .weekend(weekend)
    );

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int week_sec(int d, int h, int m, int s);
        return d * 86400 + h * 3600 + m * 60 + s;
    endfunction

    function automatic bit exp_weekend(int d, int h, int m, int s);
        int t = week_sec(d, h, m, s);
        return (t < week_sec(0, 9, 0, 0)) || (t >= week_sec(4, 17, 0, 0));
    endfunction

    // packed expected BCD {days, hours, mins, secs}
    function automatic logic [31:0] exp_rem(int d, int h, int m, int s);
        int r;
        if (exp_weekend(d, h, m, s)) return 32'd0;
        r = week_sec(4, 17, 0, 0) - week_sec(d, h, m, s);
        return {8'(to_bcd(r / 86400)), 8'(to_bcd((r % 86400) / 3600)),
                8'(to_bcd((r % 3600) / 60)), 8'(to_bcd(r % 60))};
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h (model %0d %0d:%0d:%0d)",
                     tag, act, exp, e_day, e_hr, e_min, e_sec);
        end
    endtask

    task automatic check_all();
        check("R2/R3/R5 time", int'({cur_day, cur_hour, cur_min, cur_sec}),
              int'({3'(e_day), 5'(e_hr), 6'(e_min), 6'(e_sec)}));
        check("R7 weekend", int'(weekend), int'(exp_weekend(e_day, e_hr, e_min, e_sec)));
        check("R8/R9 remaining", int'({rem_days, rem_hours, rem_mins, rem_secs}),
              int'(exp_rem(e_day, e_hr, e_min, e_sec)));
    endtask

    // one clock: drive, advance model across the edge, check away from the edge
    task automatic cyc(bit r, bit t, bit s, bit id, bit ih, bit im);
        rst = r; tick = t; set_mode = s; inc_day = id; inc_hour = ih; inc_min = im;
        @(posedge clk);
        if (r) begin
            e_day = 0; e_hr = 0; e_min = 0; e_sec = 0;
        end else if (s) begin
            if (id) e_day = (e_day + 1) % 7;
            if (ih) e_hr  = (e_hr + 1) % 24;
            if (im) e_min = (e_min + 1) % 60;
        end else if (e_setq) begin
            e_sec = 0;
        end else if (t) begin
            e_sec++;
            if (e_sec == 60) begin e_sec = 0; e_min++; end
            if (e_min == 60) begin e_min = 0; e_hr++; end
            if (e_hr == 24)  begin e_hr = 0; e_day = (e_day + 1) % 7; end
        end
        e_setq = s;
        #1;
        check_all();
    endtask

    task automatic set_time(int d, int h, int m);
        cyc(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 60; i++)
            cyc(0, 1, 1, i < d, i < h, i < m);
        cyc(0, 1, 0, 0, 0, 0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 0);
    endtask

    initial begin
        #700000;
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        bit sm;
        e_day = 0; e_hr = 0; e_min = 0; e_sec = 0; e_setq = 0;
        // R1: reset state
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        check("R1 reset time", int'({cur_day, cur_hour, cur_min, cur_sec}), 0);
        check("R7 Monday early is weekend", int'(weekend), 1);

        // R7/R8: Friday 16:59:59 -> 17:00:00
        set_time(4, 16, 59);
        check("R6 seconds cleared on exit", int'(cur_sec), 0);
        ticks(59);
        check("R8 one second left", int'({rem_days, rem_hours, rem_mins, rem_secs}), 32'h00000001);
        check("R7 still working week", int'(weekend), 0);
        ticks(1);
        check("R7 deadline raises weekend", int'(weekend), 1);
        check("R9 blanked at deadline", int'({rem_days, rem_hours, rem_mins, rem_secs}), 0);

        // R7/R8: Monday 08:59:59 -> 09:00:00
        set_time(0, 8, 59);
        ticks(59);
        check("R7 08:59:59 weekend", int'(weekend), 1);
        ticks(1);
        check("R8 full week left", int'({rem_days, rem_hours, rem_mins, rem_secs}), 32'h04080000);

        // R3: Sunday 23:59:59 wraps to Monday 00:00:00
        set_time(6, 23, 59);
        ticks(60);
        check("R3 week wrap", int'({cur_day, cur_hour, cur_min, cur_sec}), 0);

        // R4/R6: tick in set mode ignored, then release clears seconds
        set_time(2, 10, 0);
        ticks(30);
        cyc(0, 1, 1, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0);
        check("R4 frozen in set mode", int'(cur_sec), 30);
        cyc(0, 1, 0, 0, 0, 0);
        check("R6 release clears seconds", int'(cur_sec), 0);

        // R5: strobes outside set mode ignored; minute wrap has no carry
        cyc(0, 0, 0, 1, 1, 1);
        check("R5 strobes ignored", int'({cur_day, cur_hour, cur_min}), int'({3'd2, 5'd10, 6'd0}));
        set_time(1, 5, 59);
        cyc(0, 0, 1, 0, 0, 1);
        check("R5 minute wrap no carry", int'({cur_hour, cur_min}), int'({5'd5, 6'd0}));
        cyc(0, 0, 0, 0, 0, 0);

        // random phase
        void'($urandom(32'h5eed_0042));
        sm = 0;
        for (int i = 0; i < 30000; i++) begin
            if ($urandom_range(0, 60) == 0) sm = !sm;
            cyc(0, $urandom_range(0, 3) != 0, sm,
                $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
                $urandom_range(0, 2) == 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule